// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Demultiplexer

This block sits between a 16-bit processor with time-shared pins and a system bus with separate address, data and control lines. The processor puts an address on its shared lines during the first clock of a bus cycle and marks that window with an address strobe. Later in the cycle it reuses the same lines for data or status. The block holds the address on the system side. It steers data in the direction that the processor's transmit/receive pin asks for, and only while the processor's data-enable pin is active. The read, write and memory/IO strobes pass straight through.

The address path is a 21-bit transparent hold register. It covers the 16 shared address/data lines, the four high address/status lines and the byte-high-enable/status line. While the strobe is high the system address follows the processor lines. When the strobe drops, the system address keeps the value captured at the last clock edge on which the strobe was high. The data path is a three-state transceiver controller:
- OFF: nothing drives either side.
- TRANSMIT: the processor drives the system bus.
- RECEIVE: the system bus drives the processor.

The controller has these transitions:
- OFF→TRANSMIT: enable active with direction high.
- OFF→RECEIVE: enable active with direction low.
- TRANSMIT→OFF: enable inactive or direction low.
- RECEIVE→OFF: enable inactive or direction high.

Entering a driving state takes one clock edge. Leaving it is immediate at the ports, because each output enable is also gated by the live pins. Any change of direction therefore passes through OFF for at least one cycle.

Top module: `bus_demux`

## Requirements
- R1: While `proc_ale` is high and reset is inactive, `{sys_bhe_n, sys_addr}` equals `{proc_bhs_n, proc_ahs, proc_ad_in}` in the same cycle. The bit order from MSB to LSB is byte-high-enable, then the high four address bits, then the low sixteen.
- R2: While `proc_ale` is low, `{sys_bhe_n, sys_addr}` holds the value sampled at the last rising clock edge at which `proc_ale` was high. If no such edge has occurred since reset, it holds zero.
- R3: While `rst_n` is low, all 21 latched bits read zero, and both `sys_d_oe` and `proc_ad_oe` are low. After reset the transceiver starts in OFF.
- R4: From OFF, a clock edge with `proc_den_n`=0 and `proc_dtr_n`=1 enters TRANSMIT. In TRANSMIT, while those pin levels hold, `sys_d_oe`=1 and `sys_d_out` equals `proc_ad_in`.
- R5: From OFF, a clock edge with `proc_den_n`=0 and `proc_dtr_n`=0 enters RECEIVE. In RECEIVE, while those pin levels hold, `proc_ad_oe`=1 and `proc_ad_out` equals `sys_d_in`.
- R6: Whenever `proc_den_n` is high, both `sys_d_oe` and `proc_ad_oe` are low in that same cycle, and the transceiver is in OFF after the next clock edge.
- R7: An output enable is never high in the cycle right after the opposite enable was high. Every direction change spends at least one cycle with both enables low.
- R8: `sys_d_oe` and `proc_ad_oe` are never high together.
- R9: `sys_rd_n`, `sys_wr_n` and `sys_mio_n` equal `proc_rd_n`, `proc_wr_n` and `proc_mio_n` in the same cycle, whatever the reset, strobe or enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_ad_in | input | 16 | Processor shared address/data lines, as driven by the processor |
| proc_ad_out | output | 16 | Value driven onto the processor shared lines during a read |
| proc_ad_oe | output | 1 | Enable for `proc_ad_out` |
| proc_ahs | input | 4 | Processor high address/status lines |
| proc_bhs_n | input | 1 | Processor byte-high-enable/status line |
| proc_ale | input | 1 | Address strobe, high while an address is on the shared lines |
| proc_den_n | input | 1 | Data transceiver enable, active low |
| proc_dtr_n | input | 1 | Transfer direction: 1 = processor to system, 0 = system to processor |
| proc_rd_n | input | 1 | Read strobe from the processor |
| proc_wr_n | input | 1 | Write strobe from the processor |
| proc_mio_n | input | 1 | Memory/IO select from the processor |
| sys_addr | output | 20 | Held system address |
| sys_bhe_n | output | 1 | Held byte-high-enable |
| sys_d_in | input | 16 | System data bus as driven by memory or IO |
| sys_d_out | output | 16 | Value driven onto the system data bus during a write |
| sys_d_oe | output | 1 | Enable for `sys_d_out` |
| sys_rd_n | output | 1 | Buffered read strobe |
| sys_wr_n | output | 1 | Buffered write strobe |
| sys_mio_n | output | 1 | Buffered memory/IO select |

## Verification
The assertions assume that every processor pin is synchronous to `clk`, changes only between rising edges, and keeps its address steady while the strobe is high, so that the value seen at an edge is the value held. The turnaround and hold properties also assume that reset is released between edges. The stimulus drives every input on the falling edge only. It runs ordered bus cycles with the strobe in the first clock and the enable in the middle clocks. It then applies long random streams with independent enable and direction flips, a mid-run reset and a directed direction reversal while the enable stays active. A behavioural model predicts every output and is compared once per cycle.

// File: rtl/busdmx_pkg.sv
package busdmx_pkg;

    typedef enum logic [1:0] {
        XC_OFF      = 2'd0,
        XC_TRANSMIT = 2'd1,
        XC_RECEIVE  = 2'd2
    } xcvr_state_e;

endpackage

// File: rtl/busdmx_addr_hold.sv
module busdmx_addr_hold #(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ale,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (ale) begin
            held_q <= d;
        end
    end

    always_comb begin
        if (!rst_n) begin
            q = '0;
        end else if (ale) begin
            q = d;
        end else begin
            q = held_q;
        end
    end

    // R2: with the strobe low the output is frozen
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && $past(!ale) && $past(rst_n)) |-> $stable(q));

    // R1/R2: value seen while strobe high is what remains after it falls
    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && $past(ale) && $past(rst_n)) |-> (q == $past(d)));

endmodule

// File: rtl/busdmx_xcvr.sv
module busdmx_xcvr
    import busdmx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         den_n,
    input  logic         dtr_n,
    input  logic [W-1:0] proc_in,
    output logic [W-1:0] proc_out,
    output logic         proc_oe,
    input  logic [W-1:0] sys_in,
    output logic [W-1:0] sys_out,
    output logic         sys_oe
);

    xcvr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XC_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XC_OFF: begin
                if (!den_n) begin
                    state_d = dtr_n ? XC_TRANSMIT : XC_RECEIVE;
                end
            end
            XC_TRANSMIT: begin
                if (den_n || !dtr_n) begin
                    state_d = XC_OFF;
                end
            end
            XC_RECEIVE: begin
                if (den_n || dtr_n) begin
                    state_d = XC_OFF;
                end
            end
            default: state_d = XC_OFF;
        endcase
    end

    always_comb begin
        sys_oe   = 1'b0;
        proc_oe  = 1'b0;
        sys_out  = proc_in;
        proc_out = sys_in;
        unique case (state_q)
            XC_OFF:      ;
            XC_TRANSMIT: sys_oe  = !den_n && dtr_n;
            XC_RECEIVE:  proc_oe = !den_n && !dtr_n;
            default:     ;
        endcase
    end

    // R6: enable released means OFF after the next edge
    a_r6_release_off: assert property (@(posedge clk) disable iff (!rst_n)
        den_n |=> (state_q == XC_OFF));

    // R7: no direct hand-over between directions
    a_r7_turn_tx_rx: assert property (@(posedge clk) disable iff (!rst_n)
        sys_oe |=> !proc_oe);
    a_r7_turn_rx_tx: assert property (@(posedge clk) disable iff (!rst_n)
        proc_oe |=> !sys_oe);

    // R4/R5: OFF with enable active picks the requested direction
    a_r4_enter_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XC_OFF && !den_n && dtr_n) |=> (state_q == XC_TRANSMIT));
    a_r5_enter_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XC_OFF && !den_n && !dtr_n) |=> (state_q == XC_RECEIVE));

endmodule

// File: rtl/busdmx_strobe_buf.sv
module busdmx_strobe_buf #(
    parameter int N = 3
) (
    input  logic [N-1:0] a,
    output logic [N-1:0] y
);

    for (genvar i = 0; i < N; i++) begin : g_buf
        assign y[i] = a[i];
    end

endmodule

// File: rtl/bus_demux.sv
module bus_demux #(
    parameter int DATA_W = 16,
    parameter int HI_W   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DATA_W-1:0]      proc_ad_in,
    output logic [DATA_W-1:0]      proc_ad_out,
    output logic                   proc_ad_oe,
    input  logic [HI_W-1:0]        proc_ahs,
    input  logic                   proc_bhs_n,
    input  logic                   proc_ale,
    input  logic                   proc_den_n,
    input  logic                   proc_dtr_n,
    input  logic                   proc_rd_n,
    input  logic                   proc_wr_n,
    input  logic                   proc_mio_n,
    output logic [DATA_W+HI_W-1:0] sys_addr,
    output logic                   sys_bhe_n,
    input  logic [DATA_W-1:0]      sys_d_in,
    output logic [DATA_W-1:0]      sys_d_out,
    output logic                   sys_d_oe,
    output logic                   sys_rd_n,
    output logic                   sys_wr_n,
    output logic                   sys_mio_n
);

    localparam int ADDR_W  = DATA_W + HI_W;
    localparam int HOLD_W  = ADDR_W + 1;
    localparam int NSTROBE = 3;

    logic [HOLD_W-1:0]  hold_q;
    logic [NSTROBE-1:0] strobe_y;

    busdmx_addr_hold #(.W(HOLD_W)) u_addr_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .ale   (proc_ale),
        .d     ({proc_bhs_n, proc_ahs, proc_ad_in}),
        .q     (hold_q)
    );

    assign sys_bhe_n = hold_q[HOLD_W-1];
    assign sys_addr  = hold_q[ADDR_W-1:0];

    busdmx_xcvr #(.W(DATA_W)) u_xcvr (
        .clk      (clk),
        .rst_n    (rst_n),
        .den_n    (proc_den_n),
        .dtr_n    (proc_dtr_n),
        .proc_in  (proc_ad_in),
        .proc_out (proc_ad_out),
        .proc_oe  (proc_ad_oe),
        .sys_in   (sys_d_in),
        .sys_out  (sys_d_out),
        .sys_oe   (sys_d_oe)
    );

    busdmx_strobe_buf #(.N(NSTROBE)) u_strobe (
        .a ({proc_mio_n, proc_wr_n, proc_rd_n}),
        .y (strobe_y)
    );

    assign sys_rd_n  = strobe_y[0];
    assign sys_wr_n  = strobe_y[1];
    assign sys_mio_n = strobe_y[2];

    // R8: the two sides are never driven at once
    a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(sys_d_oe && proc_ad_oe));

    // R3: reset forces both enables and the address low
    always_comb begin
        if (!rst_n) begin
            a_r3_reset_quiet: assert (!sys_d_oe && !proc_ad_oe && hold_q == '0);
        end
    end

endmodule

// File: tb/test_bus_demux.sv
module test_bus_demux;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [15:0] ad_in, ad_out, sd_in, sd_out;
    logic        ad_oe, sd_oe;
    logic [3:0]  ahs;
    logic        bhs_n, ale, den_n, dtr_n, rd_n, wr_n, mio_n;
    logic [19:0] s_addr;
    logic        s_bhe_n, s_rd_n, s_wr_n, s_mio_n;

    bus_demux i_bus_demux (
        .clk(clk), .rst_n(rst_n),
        .proc_ad_in(ad_in), .proc_ad_out(ad_out), .proc_ad_oe(ad_oe),
        .proc_ahs(ahs), .proc_bhs_n(bhs_n), .proc_ale(ale),
        .proc_den_n(den_n), .proc_dtr_n(dtr_n),
        .proc_rd_n(rd_n), .proc_wr_n(wr_n), .proc_mio_n(mio_n),
        .sys_addr(s_addr), .sys_bhe_n(s_bhe_n),
        .sys_d_in(sd_in), .sys_d_out(sd_out), .sys_d_oe(sd_oe),
        .sys_rd_n(s_rd_n), .sys_wr_n(s_wr_n), .sys_mio_n(s_mio_n)
    );

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: held word and direction (0 off, 1 tx, 2 rx)
    logic [20:0] m_held;
    int          m_dir;
    logic        prev_soe, prev_poe;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_held <= '0;
            m_dir  <= 0;
        end else begin
            if (ale) m_held <= {bhs_n, ahs, ad_in};
            if (m_dir == 0) begin
                if (!den_n) m_dir <= dtr_n ? 1 : 2;
            end else if (m_dir == 1) begin
                if (den_n || !dtr_n) m_dir <= 0;
            end else begin
                if (den_n || dtr_n) m_dir <= 0;
            end
        end
    end

    task automatic compare_all();
        logic [20:0] e_addr;
        logic        e_soe, e_poe;
        string       at, ot;
        e_addr = !rst_n ? 21'd0 : (ale ? {bhs_n, ahs, ad_in} : m_held);
        at     = !rst_n ? "R3" : (ale ? "R1" : "R2");
        chk(at, {s_bhe_n, s_addr}, e_addr);
        e_soe = rst_n && m_dir == 1 && !den_n && dtr_n;
        e_poe = rst_n && m_dir == 2 && !den_n && !dtr_n;
        ot = !rst_n ? "R3" : (den_n ? "R6" : "R4");
        chk(ot, sd_oe, e_soe);
        ot = !rst_n ? "R3" : (den_n ? "R6" : "R5");
        chk(ot, ad_oe, e_poe);
        if (e_soe) chk("R4", sd_out, ad_in);
        if (e_poe) chk("R5", ad_out, sd_in);
        chk("R8", sd_oe && ad_oe, 0);
        if (rst_n) chk("R7", (prev_soe && ad_oe) || (prev_poe && sd_oe), 0);
        chk("R9", {s_mio_n, s_wr_n, s_rd_n}, {mio_n, wr_n, rd_n});
        prev_soe = sd_oe;
        prev_poe = ad_oe;
    endtask

    task automatic step();
        #3;
        compare_all();
        @(negedge clk);
    endtask

    task automatic bus_cycle(logic [19:0] a, logic bh, logic wr);
        ale = 1; ad_in = a[15:0]; ahs = a[19:16]; bhs_n = bh;
        den_n = 1; dtr_n = wr; mio_n = a[0];
        step();
        ale = 0; ahs = $urandom; bhs_n = $urandom; ad_in = $urandom;
        den_n = 0; rd_n = wr; wr_n = !wr; sd_in = $urandom;
        step();
        ad_in = $urandom; sd_in = $urandom;
        step();
        step();
        den_n = 1; rd_n = 1; wr_n = 1;
        step();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ad_in = 16'h1234; sd_in = 16'h5678; ahs = 4'hF; bhs_n = 1;
        ale = 1; den_n = 0; dtr_n = 1; rd_n = 0; wr_n = 1; mio_n = 0;
        prev_soe = 0; prev_poe = 0;
        @(negedge clk);
        step();   // R3: reset with strobe and enable active
        step();
        rst_n = 1; ale = 0; den_n = 1;
        step();   // R2: nothing captured since reset, still zero

        for (int i = 0; i < 60; i++) begin
            bus_cycle(20'($urandom), 1'($urandom), 1'(i % 2));
        end

        // R7 directed reversal with the enable held active
        ale = 0; den_n = 0; dtr_n = 1;
        for (int i = 0; i < 4; i++) step();
        dtr_n = 0;
        for (int i = 0; i < 4; i++) step();
        dtr_n = 1;
        for (int i = 0; i < 4; i++) step();

        // random streams, with a reset in the middle
        for (int i = 0; i < 4000; i++) begin
            ad_in = $urandom; sd_in = $urandom; ahs = $urandom; bhs_n = $urandom;
            ale = ($urandom % 4) == 0;
            if (($urandom % 5) == 0) den_n = ~den_n;
            if (($urandom % 7) == 0) dtr_n = ~dtr_n;
            rd_n = $urandom; wr_n = $urandom; mio_n = $urandom;
            if (i == 2000) rst_n = 0;
            if (i == 2003) rst_n = 1;
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule